// File: doc/BRIEF.md
# Per-Lane Drive Adjust Decoder

This block sits in the transmit side of a multi-lane serial display link during link training. After each status read, the receiving sink reports, per lane, the voltage swing and pre-emphasis it would like the source to use, plus an optional second post-cursor level. The decoder unpacks those packed requests, holds each lane inside the legal drive envelope, and produces two things at once: the per-lane setting bytes that the source writes back to the sink, and the plain 2-bit swing, pre-emphasis and post-cursor levels that go to the PHY drivers.

The envelope rule couples the two main levels. Swing plus pre-emphasis may never exceed 3. A saturated pre-emphasis request forces the swing down to whatever room is left. A swing request that reaches its limit is clamped to it. When a field is clamped, a "max reached" flag is set in bit 2 of that field in the written-back byte, so the sink knows not to ask for more. Lanes at or above the active lane count are driven to zero on every output.

A run is started by a one-cycle `start_i` strobe. The results are registered and held until the next strobe, and `done_o` marks the cycle in which they first appear.

Top module: `lane_drive_adjust`

## Requirements
- R1: While `rst_i` is high and after it falls, with no strobe yet, every output is zero and `done_o` is low.
- R2: When `start_i` is high at a rising clock edge, all result outputs take the decoded values of the inputs sampled at that edge, and `done_o` is high for the cycle that follows. When `start_i` is low at an edge, `done_o` is low after it and every result output keeps its value.
- R3: The request for lane i is the 4-bit nibble in adjust byte i/2 (byte k at `adj_req_i[8k+7:8k]`), taken from bits 3:0 for even i and bits 7:4 for odd i. Within the nibble, bits 3:2 hold the pre-emphasis request and bits 1:0 the swing request.
- R4: A pre-emphasis request of 3 gives a pre-emphasis field of 3 with its flag (bit 2) set, i.e. 7. The swing field is then 0 with no flag.
- R5: A pre-emphasis request p below 3, together with a swing request of at least 3-p, gives a swing field of (3-p) with its flag bit 2 set, and a pre-emphasis field of p without the flag.
- R6: In all other cases both fields equal their requests and carry no flag.
- R7: The setting byte of lane i sits at `lane_set_o[8i+7:8i]` and equals (pre-emphasis field << 3) | swing field, with bits 7:6 zero.
- R8: The post-cursor request of lane i is `pc2_req_i[2i+1:2i]`. A request of 3 gives a field of 7 (value 3 plus flag bit 2). Any other request gives a field equal to the request.
- R9: The post-cursor fields are packed in nibbles into `pc2_set_o`. Lane i goes to byte i/2, in the low nibble for even i and the high nibble for odd i, which places it at bits 4i+3:4i. Bit 3 of each nibble is zero.
- R10: `drv_swing_o`, `drv_pre_o` and `drv_pc2_o` carry, for lane i at bits 2i+1:2i, the low two bits of the corresponding field, with the flag removed.
- R11: Every output slice of a lane whose index is not below `lane_cnt_i` is zero, whatever the requests. This includes its post-cursor nibble, so no bits survive from an earlier run with more lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Strobe: decode the present inputs |
| lane_cnt_i | input | 3 | Number of active lanes (1, 2 or 4) |
| adj_req_i | input | 16 | Two packed adjust-request bytes, one nibble per lane |
| pc2_req_i | input | 8 | Packed post-cursor requests, 2 bits per lane |
| lane_set_o | output | 32 | Per-lane setting bytes with max-reached flags |
| pc2_set_o | output | 16 | Post-cursor fields, one nibble per lane |
| drv_swing_o | output | 8 | PHY swing level, 2 bits per lane |
| drv_pre_o | output | 8 | PHY pre-emphasis level, 2 bits per lane |
| drv_pc2_o | output | 8 | PHY post-cursor level, 2 bits per lane |
| done_o | output | 1 | High in the cycle after a strobe |

## Verification
The two functions that meet in one cycle are pre-emphasis saturation and swing clamping. A nibble of all ones asks for the highest level of both at once, and only the pre-emphasis rule may win. That lane must read 0x38 with a zero swing field, while a neighbouring lane that asks for swing 3 at pre-emphasis 0 must read 0x07. A second collision is a strobe held over two edges with new inputs in between. The outputs must follow the second set one cycle after the first, and `done_o` must stay high for both cycles. A full sweep of request bytes under two lane counts is then compared against a model built from the requirements.

// File: rtl/lda_pkg.sv
package lda_pkg;

    // Width of one drive level (swing, pre-emphasis, post-cursor).
    localparam int LVL_W  = 2;
    // A written-back field is the level plus one max-reached flag above it.
    localparam int FLD_W  = LVL_W + 1;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_MAX = '1;

    // Field as written back: flag sits directly above the level bits.
    typedef struct packed {
        logic hit;
        lvl_t lvl;
    } fld_t;

    typedef struct packed {
        lvl_t pre;
        lvl_t sw;
        lvl_t pc2;
    } lane_req_t;

    typedef struct packed {
        fld_t pre;
        fld_t sw;
        fld_t pc2;
    } lane_fld_t;

    // Independent saturation for a level with no coupling to another level.
    function automatic fld_t sat_fld(lvl_t req);
        fld_t f;
        if (req == LVL_MAX) begin
            f.hit = 1'b1;
            f.lvl = LVL_MAX;
        end else begin
            f.hit = 1'b0;
            f.lvl = req;
        end
        return f;
    endfunction

    // Setting byte: pre-emphasis field above the swing field.
    function automatic logic [BYTE_W-1:0] lane_byte(fld_t pre, fld_t sw);
        return {{(BYTE_W - 2*FLD_W){1'b0}}, pre, sw};
    endfunction

    // Post-cursor field zero-extended into one nibble.
    function automatic logic [NIB_W-1:0] pc2_nib(fld_t f);
        return {{(NIB_W - FLD_W){1'b0}}, f};
    endfunction

endpackage

// File: rtl/lda_req_unpack.sv
module lda_req_unpack
    import lda_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic [NUM_LANES/2*BYTE_W-1:0] adj_req_i,
    input  logic [NUM_LANES*LVL_W-1:0]    pc2_req_i,
    output lane_req_t [NUM_LANES-1:0]     req_o
);

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        // Two lanes share one request byte; odd lanes use the high nibble.
        localparam int NIB_POS = (ln / 2) * BYTE_W + (ln % 2) * NIB_W;

        logic [NIB_W-1:0] nib;

        assign nib            = adj_req_i[NIB_POS +: NIB_W];
        assign req_o[ln].pre  = nib[2*LVL_W-1:LVL_W];
        assign req_o[ln].sw   = nib[LVL_W-1:0];
        assign req_o[ln].pc2  = pc2_req_i[ln*LVL_W +: LVL_W];
    end

endmodule

// File: rtl/lda_lane_clamp.sv
module lda_lane_clamp
    import lda_pkg::*;
(
    input  lane_req_t req_i,
    output lane_fld_t fld_o
);

    // Room left for swing once pre-emphasis is accounted for.
    lvl_t room;

    always_comb begin
        room      = LVL_MAX - req_i.pre;
        fld_o.pc2 = sat_fld(req_i.pc2);

        if (req_i.pre == LVL_MAX) begin
            // Saturated pre-emphasis wins; swing gets the leftover room.
            fld_o.pre.hit = 1'b1;
            fld_o.pre.lvl = LVL_MAX;
            fld_o.sw.hit  = 1'b0;
            fld_o.sw.lvl  = room;
        end else if (req_i.sw >= room) begin
            fld_o.pre.hit = 1'b0;
            fld_o.pre.lvl = req_i.pre;
            fld_o.sw.hit  = 1'b1;
            fld_o.sw.lvl  = room;
        end else begin
            fld_o.pre.hit = 1'b0;
            fld_o.pre.lvl = req_i.pre;
            fld_o.sw.hit  = 1'b0;
            fld_o.sw.lvl  = req_i.sw;
        end
    end

endmodule

// File: rtl/lda_pack.sv
module lda_pack
    import lda_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int CNT_W     = 3
) (
    input  lane_fld_t [NUM_LANES-1:0]     fld_i,
    input  logic [CNT_W-1:0]              lane_cnt_i,
    output logic [NUM_LANES*BYTE_W-1:0]   lane_set_o,
    output logic [NUM_LANES/2*BYTE_W-1:0] pc2_set_o,
    output logic [NUM_LANES*LVL_W-1:0]    drv_swing_o,
    output logic [NUM_LANES*LVL_W-1:0]    drv_pre_o,
    output logic [NUM_LANES*LVL_W-1:0]    drv_pc2_o
);

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        logic active;

        assign active = (CNT_W'(ln) < lane_cnt_i);

        assign lane_set_o[ln*BYTE_W +: BYTE_W] =
            active ? lane_byte(fld_i[ln].pre, fld_i[ln].sw) : '0;

        // Nibble position ln*NIB_W equals byte ln/2, nibble ln%2.
        assign pc2_set_o[ln*NIB_W +: NIB_W] =
            active ? pc2_nib(fld_i[ln].pc2) : '0;

        assign drv_swing_o[ln*LVL_W +: LVL_W] = active ? fld_i[ln].sw.lvl  : '0;
        assign drv_pre_o[ln*LVL_W +: LVL_W]   = active ? fld_i[ln].pre.lvl : '0;
        assign drv_pc2_o[ln*LVL_W +: LVL_W]   = active ? fld_i[ln].pc2.lvl : '0;
    end

endmodule

// File: rtl/lane_drive_adjust.sv
module lane_drive_adjust
    import lda_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                                 clk_i,
    input  logic                                 rst_i,
    input  logic                                 start_i,
    input  logic [$clog2(NUM_LANES+1)-1:0]       lane_cnt_i,
    input  logic [NUM_LANES/2*BYTE_W-1:0]        adj_req_i,
    input  logic [NUM_LANES*LVL_W-1:0]           pc2_req_i,
    output logic [NUM_LANES*BYTE_W-1:0]          lane_set_o,
    output logic [NUM_LANES/2*BYTE_W-1:0]        pc2_set_o,
    output logic [NUM_LANES*LVL_W-1:0]           drv_swing_o,
    output logic [NUM_LANES*LVL_W-1:0]           drv_pre_o,
    output logic [NUM_LANES*LVL_W-1:0]           drv_pc2_o,
    output logic                                 done_o
);

    localparam int CNT_W   = $clog2(NUM_LANES + 1);
    localparam int SET_W   = NUM_LANES * BYTE_W;
    localparam int PC2_W   = NUM_LANES / 2 * BYTE_W;
    localparam int DRV_W   = NUM_LANES * LVL_W;

    lane_req_t [NUM_LANES-1:0] req;
    lane_fld_t [NUM_LANES-1:0] fld;

    logic [SET_W-1:0] set_d,   set_q;
    logic [PC2_W-1:0] pc2s_d,  pc2s_q;
    logic [DRV_W-1:0] swing_d, swing_q;
    logic [DRV_W-1:0] pre_d,   pre_q;
    logic [DRV_W-1:0] pc2d_d,  pc2d_q;
    logic             done_q;

    lda_req_unpack #(
        .NUM_LANES (NUM_LANES)
    ) unpack_i (
        .adj_req_i (adj_req_i),
        .pc2_req_i (pc2_req_i),
        .req_o     (req)
    );

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_clamp
        lda_lane_clamp clamp_i (
            .req_i (req[ln]),
            .fld_o (fld[ln])
        );
    end

    lda_pack #(
        .NUM_LANES (NUM_LANES),
        .CNT_W     (CNT_W)
    ) pack_i (
        .fld_i       (fld),
        .lane_cnt_i  (lane_cnt_i),
        .lane_set_o  (set_d),
        .pc2_set_o   (pc2s_d),
        .drv_swing_o (swing_d),
        .drv_pre_o   (pre_d),
        .drv_pc2_o   (pc2d_d)
    );

    // Whole result words are replaced on every strobe, so nothing from an
    // earlier run can linger in a lane that is now inactive.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            set_q   <= '0;
            pc2s_q  <= '0;
            swing_q <= '0;
            pre_q   <= '0;
            pc2d_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= start_i;
            if (start_i) begin
                set_q   <= set_d;
                pc2s_q  <= pc2s_d;
                swing_q <= swing_d;
                pre_q   <= pre_d;
                pc2d_q  <= pc2d_d;
            end
        end
    end

    assign lane_set_o  = set_q;
    assign pc2_set_o   = pc2s_q;
    assign drv_swing_o = swing_q;
    assign drv_pre_o   = pre_q;
    assign drv_pc2_o   = pc2d_q;
    assign done_o      = done_q;

endmodule

// File: rtl/lane_drive_adjust_chk.sv
module lane_drive_adjust_chk
    import lda_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input logic                                 clk_i,
    input logic                                 rst_i,
    input logic                                 start_i,
    input logic [$clog2(NUM_LANES+1)-1:0]       lane_cnt_i,
    input logic [NUM_LANES*BYTE_W-1:0]          lane_set_o,
    input logic [NUM_LANES/2*BYTE_W-1:0]        pc2_set_o,
    input logic [NUM_LANES*LVL_W-1:0]           drv_swing_o,
    input logic [NUM_LANES*LVL_W-1:0]           drv_pre_o,
    input logic [NUM_LANES*LVL_W-1:0]           drv_pc2_o,
    input logic                                 done_o
);

    localparam int CNT_W = $clog2(NUM_LANES + 1);

    // R2
    strobe_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> done_o);

    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_i |=> (!done_o && $stable(lane_set_o) && $stable(pc2_set_o)
                      && $stable(drv_swing_o) && $stable(drv_pre_o)));

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        localparam int BASE     = ln * BYTE_W;
        localparam int PRE_FLAG = BASE + 2 * FLD_W - 1;

        // R4
        pre_sat_swing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            lane_set_o[PRE_FLAG] |-> (lane_set_o[BASE +: FLD_W] == '0));

        // R5
        level_sum_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            ({1'b0, drv_swing_o[ln*LVL_W +: LVL_W]}
             + {1'b0, drv_pre_o[ln*LVL_W +: LVL_W]}) <= {1'b0, LVL_MAX});

        // R8
        pc2_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            pc2_set_o[ln*NIB_W + LVL_W] |-> (drv_pc2_o[ln*LVL_W +: LVL_W] == LVL_MAX));

        // R11
        idle_lane_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (start_i && (lane_cnt_i <= CNT_W'(ln))) |=>
            (lane_set_o[BASE +: BYTE_W] == '0 && pc2_set_o[ln*NIB_W +: NIB_W] == '0
             && drv_swing_o[ln*LVL_W +: LVL_W] == '0 && drv_pre_o[ln*LVL_W +: LVL_W] == '0
             && drv_pc2_o[ln*LVL_W +: LVL_W] == '0));
    end

endmodule

bind lane_drive_adjust lane_drive_adjust_chk #(
    .NUM_LANES (NUM_LANES)
) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .lane_cnt_i  (lane_cnt_i),
    .lane_set_o  (lane_set_o),
    .pc2_set_o   (pc2_set_o),
    .drv_swing_o (drv_swing_o),
    .drv_pre_o   (drv_pre_o),
    .drv_pc2_o   (drv_pc2_o),
    .done_o      (done_o)
);

// File: tb/lane_drive_adjust_tb_top.sv
module lane_drive_adjust_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  lane_cnt = 3'd4;
    logic [15:0] adj_req = '0;
    logic [7:0]  pc2_req = '0;
    logic [31:0] lane_set;
    logic [15:0] pc2_set;
    logic [7:0]  drv_swing, drv_pre, drv_pc2;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [31:0] e_set;
    logic [15:0] e_pc2s;
    logic [7:0]  e_sw, e_pre, e_pc2d;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_drive_adjust dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .start_i     (start),
        .lane_cnt_i  (lane_cnt),
        .adj_req_i   (adj_req),
        .pc2_req_i   (pc2_req),
        .lane_set_o  (lane_set),
        .pc2_set_o   (pc2_set),
        .drv_swing_o (drv_swing),
        .drv_pre_o   (drv_pre),
        .drv_pc2_o   (drv_pc2),
        .done_o      (done)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Expected outputs derived from the requirement text.
    task automatic model(logic [15:0] adj, logic [7:0] pc2, logic [2:0] cnt);
        e_set = '0; e_pc2s = '0; e_sw = '0; e_pre = '0; e_pc2d = '0;
        for (int i = 0; i < 4; i++) begin
            int n, p, s, c, pf, sf, cf;
            n = (adj >> (8*(i/2) + 4*(i%2))) & 15;
            p = (n >> 2) & 3;
            s = n & 3;
            c = (pc2 >> (2*i)) & 3;
            if (p == 3) begin pf = 7; sf = 0; end
            else if (s >= 3 - p) begin pf = p; sf = (3 - p) + 4; end
            else begin pf = p; sf = s; end
            cf = (c == 3) ? 7 : c;
            if (i < int'(cnt)) begin
                e_set  = e_set  | (32'(pf*8 + sf) << (8*i));
                e_pc2s = e_pc2s | (16'(cf) << (4*i));
                e_sw   = e_sw   | (8'(sf & 3) << (2*i));
                e_pre  = e_pre  | (8'(pf & 3) << (2*i));
                e_pc2d = e_pc2d | (8'(cf & 3) << (2*i));
            end
        end
    endtask

    task automatic cmp_all(string req);
        chk(req, "lane_set", lane_set, e_set);
        chk(req, "pc2_set", 32'(pc2_set), 32'(e_pc2s));
        chk(req, "drv_swing", 32'(drv_swing), 32'(e_sw));
        chk(req, "drv_pre", 32'(drv_pre), 32'(e_pre));
        chk(req, "drv_pc2", 32'(drv_pc2), 32'(e_pc2d));
    endtask

    // Strobe for one cycle; sample on the following falling edge.
    task automatic run(logic [15:0] adj, logic [7:0] pc2, logic [2:0] cnt);
        @(negedge clk);
        adj_req = adj; pc2_req = pc2; lane_cnt = cnt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "done after strobe", 32'(done), 32'd1);
        model(adj, pc2, cnt);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "lane_set", lane_set, 32'd0);
        chk("R1", "pc2_set", 32'(pc2_set), 32'd0);
        chk("R1", "drv", {8'd0, drv_swing, drv_pre, drv_pc2}, 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
    endtask

    task automatic t_swing_limit;
        // lane0 0x6 -> 0x0E, lane1 0x1 -> 0x01, lane2 0x9 -> 0x15, lane3 0x2 -> 0x02
        run(16'h2916, 8'h00, 3'd4);
        chk("R5", "lane0 clamped swing", 32'(lane_set[7:0]), 32'h0E);
        chk("R5", "lane2 clamped swing", 32'(lane_set[23:16]), 32'h15);
        chk("R6", "lane1 pass", 32'(lane_set[15:8]), 32'h01);
        chk("R7", "byte layout", lane_set, 32'h0215_010E);
        cmp_all("R6");
        @(negedge clk);
        chk("R2", "done single cycle", 32'(done), 32'd0);
    endtask

    task automatic t_pre_max;
        // lane0 F, lane1 3, lane2 F, lane3 C
        run(16'hCF3F, 8'h00, 3'd4);
        chk("R4", "pre saturation", lane_set, 32'h3838_0738);
        chk("R10", "drv_pre stripped", 32'(drv_pre), 32'hF3);
        chk("R10", "drv_swing stripped", 32'(drv_swing), 32'h0C);
        cmp_all("R4");
    endtask

    task automatic t_pc2;
        run(16'h0000, 8'hE7, 3'd4);
        chk("R8", "pc2 fields", 32'(pc2_set), 32'h7217);
        chk("R9", "pc2 nibble order", 32'(pc2_set[7:4]), 32'h1);
        chk("R10", "drv_pc2", 32'(drv_pc2), 32'hE7);
        cmp_all("R8");
    endtask

    task automatic t_lane_mask;
        run(16'hFFFF, 8'hFF, 3'd4);
        chk("R11", "all lanes pc2", 32'(pc2_set), 32'h7777);
        run(16'hFFFF, 8'hFF, 3'd2);
        chk("R11", "two lanes set", lane_set, 32'h0000_3838);
        chk("R11", "two lanes pc2", 32'(pc2_set), 32'h0077);
        chk("R11", "two lanes drv", {8'd0, drv_swing, drv_pre, drv_pc2}, 32'h00_0F0F);
        run(16'hFFFF, 8'hFF, 3'd1);
        chk("R11", "one lane no stale pc2", 32'(pc2_set), 32'h0007);
        chk("R11", "one lane set", lane_set, 32'h0000_0038);
        run(16'hFFFF, 8'hFF, 3'd0);
        cmp_all("R11");
    endtask

    task automatic t_hold;
        logic [31:0] s0;
        logic [15:0] p0;
        run(16'h2916, 8'hE7, 3'd4);
        s0 = lane_set; p0 = pc2_set;
        adj_req = 16'hFFFF; pc2_req = 8'h00; lane_cnt = 3'd1;
        repeat (3) @(negedge clk);
        chk("R2", "hold lane_set", lane_set, s0);
        chk("R2", "hold pc2_set", 32'(pc2_set), 32'(p0));
        chk("R2", "idle done", 32'(done), 32'd0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        adj_req = 16'hCF3F; pc2_req = 8'h00; lane_cnt = 3'd4; start = 1'b1;
        @(negedge clk);
        model(16'hCF3F, 8'h00, 3'd4);
        chk("R2", "b2b first done", 32'(done), 32'd1);
        cmp_all("R2");
        adj_req = 16'h2916; pc2_req = 8'hE7; lane_cnt = 3'd2;
        @(negedge clk);
        start = 1'b0;
        model(16'h2916, 8'hE7, 3'd2);
        chk("R2", "b2b second done", 32'(done), 32'd1);
        cmp_all("R2");
        @(negedge clk);
        chk("R2", "b2b done falls", 32'(done), 32'd0);
    endtask

    task automatic t_sweep;
        for (int k = 0; k < 256; k++) begin
            run({8'(k ^ 8'h5A), 8'(k)}, 8'(k * 3), (k % 2 == 0) ? 3'd4 : 3'd2);
            cmp_all("R3");
        end
    endtask

    initial begin
        t_reset();
        t_swing_limit();
        t_pre_max();
        t_pc2();
        t_lane_mask();
        t_hold();
        t_back_to_back();
        t_sweep();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule